// File: doc/BRIEF.md
# Serial Word Receiver and Code Register for a Voltage-Output DAC

This block is the digital front end of a single-channel converter. A host sends 24-bit words over a three-wire link made of a low-active frame select, a serial clock and a data line. The block oversamples all three lines with its own system clock and moves data in on each falling serial-clock edge while the frame select is low. It acts on a word only when the word is complete. From each accepted word it keeps a 16-bit conversion code and a 2-bit power-down setting. It then tells the analog side whether the output amplifier drives the pin or which termination replaces it.

Two special cases are handled. A word of all ones restores the power-on state, and a frame select that rises early cannot cancel it once it has started. The power-on code is zero-scale or midscale, chosen by a strap input. When the block leaves power-down, a cycle counter models the time the analog circuits need to wake. A ready flag rises when that count runs out, and the count is chosen for the supply voltage.

Top module: `dac_serial_front`

## Requirements
- R1: A word is 24 bits, sent most significant bit first. A bit is taken on each falling serial-clock edge while the frame select is low. The word takes effect at the 24th such edge, and bits 15..0 carry the conversion code.
- R2: If the frame select goes high before the 24th falling edge, the word is dropped. The code and the power-down setting stay as they were.
- R3: Bits 17..16 select the output state. 00 means the amplifier drives. 01 means open, 10 means 100 kΩ to ground and 11 means 1 kΩ to ground. Exactly one of the four output selects is high at any time.
- R4: A complete word with a nonzero bits 17..16 changes only the power-down setting and leaves the code unchanged. Bits 23..18 have no effect on a normal word.
- R5: After hardware reset the code is 0x0000 when cfg_midscale is 0 and 0x8000 when it is 1. The output is in normal drive and out_ready is high.
- R6: A complete word of 24 ones restores the code to the value selected by cfg_midscale and sets the output to normal drive.
- R7: Once the first 8 bits of a word are all ones, a reset is committed, and an early rise of the frame select still carries it out. A complete word that starts with 8 ones but holds a zero later is treated as a normal word.
- R8: out_ready is low while the block is in power-down. It rises EXIT_CYC system-clock cycles after the output setting returns to normal drive. EXIT_CYC is 313 for the 5 V supply option and 625 for the 3 V option.
- R9: When the 24th falling edge and the rise of the frame select are seen in the same sample, the edge counts and the word is accepted.
- R10: Falling edges after the 24th are ignored while the frame select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cfg_midscale | input | 1 | Power-on code select: 0 gives zero-scale, 1 gives midscale |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sync_n | input | 1 | Low-active frame select |
| din | input | 1 | Serial data, most significant bit first |
| dac_code | output | 16 | Code held for the converter core |
| pd_mode | output | 2 | Current power-down setting (00 means normal) |
| amp_drive | output | 1 | Amplifier connected to the output pin |
| term_open | output | 1 | Output left open-circuit |
| term_100k | output | 1 | Output tied to ground through 100 kΩ |
| term_1k | output | 1 | Output tied to ground through 1 kΩ |
| out_ready | output | 1 | The output has finished waking from power-down |

## Verification
Two things can land in the same oversampling cycle: the 24th falling edge that completes a word and the rise of the frame select that would cancel it. The bench creates this case by changing the serial clock and the frame select on the same system-clock edge. Both lines then pass through equal synchronizer depths. The bench judges the case by whether the code in that word appears on dac_code. A second, similar case is a frame select that rises while a reset word is already committed. The bench checks that the power-on code still comes back.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;

   typedef enum logic [1:0] {
      PD_NONE = 2'b00,
      PD_OPEN = 2'b01,
      PD_100K = 2'b10,
      PD_1K   = 2'b11
   } pd_mode_e;

   typedef struct packed {
      logic sclk;
      logic sync_n;
      logic din;
   } ser_lines_t;

   localparam ser_lines_t SER_IDLE = '{sclk: 1'b1, sync_n: 1'b1, din: 1'b0};

   function automatic logic [3:0] term_decode(input pd_mode_e m);
      case (m)
         PD_NONE: term_decode = 4'b1000;
         PD_OPEN: term_decode = 4'b0100;
         PD_100K: term_decode = 4'b0010;
         default: term_decode = 4'b0001;
      endcase
   endfunction

endpackage

// File: rtl/ser_line_sampler.sv
module ser_line_sampler
   import dac_if_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic sync_n,
   input  logic din,
   output logic sclk_fall,
   output logic sync_hi,
   output logic sync_was_lo,
   output logic sync_rise,
   output logic din_s
);

   ser_lines_t raw, cur, prev;

   assign raw = '{sclk: sclk, sync_n: sync_n, din: din};

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("ser_line_sampler: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_direct
         assign cur = raw;
      end else begin : g_chain
         ser_lines_t chain [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) chain[k] <= SER_IDLE;
            end else begin
               chain[0] <= raw;
               for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
            end
         end
         assign cur = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= SER_IDLE;
      else        prev <= cur;
   end

   assign sclk_fall   = prev.sclk & ~cur.sclk;
   assign sync_hi     = cur.sync_n;
   assign sync_was_lo = ~prev.sync_n;
   assign sync_rise   = ~prev.sync_n & cur.sync_n;
   assign din_s       = cur.din;

endmodule

// File: rtl/word_assembler.sv
module word_assembler #(
   parameter int FRAME_W  = 24,
   parameter int ARM_BITS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_fall,
   input  logic               sync_hi,
   input  logic               sync_was_lo,
   input  logic               sync_rise,
   input  logic               din_s,
   output logic               frame_wr,
   output logic               sw_rst,
   output logic [FRAME_W-1:0] frame_word
);

   localparam int CW = $clog2(FRAME_W + 1);
   localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_W - 1);
   localparam logic [CW-1:0] ARM_IDX  = CW'(ARM_BITS - 1);
   localparam logic [CW-1:0] FULL     = CW'(FRAME_W);

   generate
      if (ARM_BITS < 1 || ARM_BITS > FRAME_W) begin : g_bad_arm
         $error("word_assembler: ARM_BITS out of range");
      end
   endgenerate

   logic [CW-1:0]      cnt;
   logic [FRAME_W-1:0] word_q;
   logic [FRAME_W-1:0] nxt_word;
   logic               armed;
   logic               edge_ok, last_bit, arm_hit, all_ones;

   assign edge_ok  = sclk_fall & sync_was_lo & (cnt != FULL);
   assign nxt_word = {word_q[FRAME_W-2:0], din_s};
   assign last_bit = edge_ok & (cnt == LAST_IDX);
   assign all_ones = &nxt_word;
   assign arm_hit  = edge_ok & (cnt == ARM_IDX) & (&nxt_word[ARM_BITS-1:0]);

   assign frame_wr   = last_bit & ~all_ones;
   assign sw_rst     = (last_bit & all_ones) | (sync_rise & (armed | arm_hit) & ~last_bit);
   assign frame_word = nxt_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         word_q <= '0;
         armed  <= 1'b0;
      end else begin
         if (edge_ok) word_q <= nxt_word;
         if (sync_hi) begin
            cnt   <= '0;
            armed <= 1'b0;
         end else begin
            if (edge_ok)  cnt   <= cnt + CW'(1);
            if (arm_hit)  armed <= 1'b1;
            if (last_bit) armed <= 1'b0;
         end
      end
   end

   // R10: the bit count stops at a full word
   assert_cnt_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL);

   // R7: a committed reset only exists after the leading bits have arrived
   assert_armed_after_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (cnt >= CW'(ARM_BITS)) && (cnt != FULL));

   // R2: nothing is written while the frame select is high and no edge was taken
   assert_no_write_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_hi && !sync_was_lo) |-> !frame_wr);

endmodule

// File: rtl/code_mode_regs.sv
module code_mode_regs
   import dac_if_pkg::*;
#(
   parameter int CODE_W   = 16,
   parameter int FRAME_W  = 24,
   parameter int MODE_LSB = 16,
   parameter int EXIT_CYC = 313
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_midscale,
   input  logic               frame_wr,
   input  logic               sw_rst,
   input  logic [FRAME_W-1:0] frame_word,
   output logic [CODE_W-1:0]  code,
   output pd_mode_e           mode,
   output logic               ready
);

   localparam int TW = $clog2(EXIT_CYC + 1);
   localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

   generate
      if (MODE_LSB < CODE_W || MODE_LSB + 2 > FRAME_W) begin : g_bad_layout
         $error("code_mode_regs: mode field overlaps code or leaves the word");
      end
      if (EXIT_CYC < 1) begin : g_bad_exit
         $error("code_mode_regs: EXIT_CYC must be at least 1");
      end
   endgenerate

   logic [CODE_W-1:0] dflt_code, nxt_code;
   pd_mode_e          nxt_mode, word_mode;
   logic [TW-1:0]     timer;
   logic              exiting;

   assign dflt_code = cfg_midscale ? MID_CODE : '0;
   assign word_mode = pd_mode_e'(frame_word[MODE_LSB+1:MODE_LSB]);

   always_comb begin
      nxt_code = code;
      nxt_mode = mode;
      if (sw_rst) begin
         nxt_code = dflt_code;
         nxt_mode = PD_NONE;
      end else if (frame_wr) begin
         nxt_mode = word_mode;
         if (word_mode == PD_NONE) nxt_code = frame_word[CODE_W-1:0];
      end
   end

   assign exiting = (mode != PD_NONE) && (nxt_mode == PD_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code  <= dflt_code;
         mode  <= PD_NONE;
         timer <= '0;
      end else begin
         code <= nxt_code;
         mode <= nxt_mode;
         if (exiting)           timer <= TW'(EXIT_CYC);
         else if (timer != '0)  timer <= timer - TW'(1);
      end
   end

   assign ready = (mode == PD_NONE) && (timer == '0);

   // R4: a power-down word keeps the code
   assert_pd_keeps_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_wr && !sw_rst && word_mode != PD_NONE) |=> $stable(code));

   // R6: a reset command lands on the strap-selected code in normal drive
   assert_swrst_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> (mode == PD_NONE) && (code == $past(dflt_code)));

   // R8: never ready while powered down
   assert_pd_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != PD_NONE) |-> !ready);

   // R8: a return to normal drive starts the wake wait
   assert_exit_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exiting |=> !ready);

endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
   import dac_if_pkg::*;
#(
   parameter int CODE_W      = 16,
   parameter int FRAME_W     = 24,
   parameter int MODE_LSB    = 16,
   parameter int ARM_BITS    = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit SUPPLY_5V   = 1'b1,
   parameter int EXIT_CYC_5V = 313,
   parameter int EXIT_CYC_3V = 625
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_midscale,
   input  logic              sclk,
   input  logic              sync_n,
   input  logic              din,
   output logic [CODE_W-1:0] dac_code,
   output logic [1:0]        pd_mode,
   output logic              amp_drive,
   output logic              term_open,
   output logic              term_100k,
   output logic              term_1k,
   output logic              out_ready
);

   localparam int EXIT_CYC = SUPPLY_5V ? EXIT_CYC_5V : EXIT_CYC_3V;

   logic               sclk_fall, sync_hi, sync_was_lo, sync_rise, din_s;
   logic               frame_wr, sw_rst;
   logic [FRAME_W-1:0] frame_word;
   pd_mode_e           mode;

   ser_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk        (sclk),
      .sync_n      (sync_n),
      .din         (din),
      .sclk_fall   (sclk_fall),
      .sync_hi     (sync_hi),
      .sync_was_lo (sync_was_lo),
      .sync_rise   (sync_rise),
      .din_s       (din_s)
   );

   word_assembler #(.FRAME_W(FRAME_W), .ARM_BITS(ARM_BITS)) u_assembler (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_fall   (sclk_fall),
      .sync_hi     (sync_hi),
      .sync_was_lo (sync_was_lo),
      .sync_rise   (sync_rise),
      .din_s       (din_s),
      .frame_wr    (frame_wr),
      .sw_rst      (sw_rst),
      .frame_word  (frame_word)
   );

   code_mode_regs #(
      .CODE_W   (CODE_W),
      .FRAME_W  (FRAME_W),
      .MODE_LSB (MODE_LSB),
      .EXIT_CYC (EXIT_CYC)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_midscale (cfg_midscale),
      .frame_wr     (frame_wr),
      .sw_rst       (sw_rst),
      .frame_word   (frame_word),
      .code         (dac_code),
      .mode         (mode),
      .ready        (out_ready)
   );

   assign pd_mode = mode;
   assign {amp_drive, term_open, term_100k, term_1k} = term_decode(mode);

   // R3: exactly one output select is active
   assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({amp_drive, term_open, term_100k, term_1k}) == 1);

   // R1: the code only moves when a word or reset has taken effect
   assert_code_moves_on_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_wr && !sw_rst) |=> $stable(dac_code));

endmodule

// File: tb/test_dac_serial_front.sv
module test_dac_serial_front;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_midscale = 1'b0;
   logic        sclk = 1'b1;
   logic        sync_n = 1'b1;
   logic        din = 1'b0;
   logic [15:0] dac_code;
   logic [1:0]  pd_mode;
   logic        amp_drive, term_open, term_100k, term_1k, out_ready;

   int checks = 0;
   int errors = 0;
   int run_len = 0;
   int measured = 0;

   localparam int EXIT_EXP = 313;
   localparam int NVEC = 13;

   // {word[23:0], nbits[4:0], coincide, expected code[15:0], expected mode[1:0]}
   localparam logic [47:0] VEC [NVEC] = '{
      {24'h001234, 5'd24, 1'b0, 16'h1234, 2'd0},  // R1 plain write
      {24'hFCABCD, 5'd24, 1'b0, 16'hABCD, 2'd0},  // R4 upper bits ignored
      {24'h005555, 5'd20, 1'b0, 16'hABCD, 2'd0},  // R2 early abort
      {24'h010000, 5'd24, 1'b0, 16'hABCD, 2'd1},  // R3 open, R4 code kept
      {24'h02FFFF, 5'd24, 1'b0, 16'hABCD, 2'd2},  // R3 100k
      {24'h030000, 5'd24, 1'b0, 16'hABCD, 2'd3},  // R3 1k
      {24'h000F0F, 5'd24, 1'b1, 16'h0F0F, 2'd0},  // R9 edge and rise together
      {24'hFFFFFF, 5'd24, 1'b0, 16'h8000, 2'd0},  // R6 reset word
      {24'h004321, 5'd24, 1'b0, 16'h4321, 2'd0},  // R1
      {24'hFF0000, 5'd12, 1'b0, 16'h8000, 2'd0},  // R7 committed reset, early rise
      {24'hFF7E00, 5'd24, 1'b0, 16'h8000, 2'd3},  // R7 leading ones, normal word
      {24'h001111, 5'd24, 1'b0, 16'h1111, 2'd0},  // R1
      {24'hFEFFFF, 5'd5,  1'b0, 16'h1111, 2'd0}   // R2 abort before commit
   };

   dac_serial_front i_dac_serial_front (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_midscale (cfg_midscale),
      .sclk         (sclk),
      .sync_n       (sync_n),
      .din          (din),
      .dac_code     (dac_code),
      .pd_mode      (pd_mode),
      .amp_drive    (amp_drive),
      .term_open    (term_open),
      .term_100k    (term_100k),
      .term_1k      (term_1k),
      .out_ready    (out_ready)
   );

   always #4 clk = ~clk;

   // wake-time monitor for R8
   always @(negedge clk) begin
      if (pd_mode != 2'd0) run_len = 0;
      else if (!out_ready) run_len = run_len + 1;
      else if (run_len > 0) begin
         measured = run_len;
         run_len = 0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [23:0] w, input int nbits, input bit coincide);
      @(negedge clk);
      sync_n = 1'b0;
      wait_cyc(4);
      for (int i = 0; i < nbits; i++) begin
         din  = (i < 24) ? w[23-i] : 1'b1;
         sclk = 1'b1;
         wait_cyc(4);
         sclk = 1'b0;
         if (coincide && i == nbits - 1) sync_n = 1'b1;
         wait_cyc(4);
      end
      sync_n = 1'b1;
      sclk   = 1'b1;
      wait_cyc(10);
   endtask

   function automatic logic [3:0] exp_sel(input logic [1:0] m);
      case (m)
         2'd0: exp_sel = 4'b1000;
         2'd1: exp_sel = 4'b0100;
         2'd2: exp_sel = 4'b0010;
         default: exp_sel = 4'b0001;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R5: zero-scale strap
      cfg_midscale = 1'b0;
      rst_n = 1'b0;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      chk("R5 code zero-scale", 32'(dac_code), 32'h0000);
      chk("R5 mode normal", 32'(pd_mode), 32'd0);
      chk("R5 ready", 32'(out_ready), 32'd1);
      chk("R3 drive at reset", 32'({amp_drive, term_open, term_100k, term_1k}), 32'b1000);

      // R5: midscale strap
      cfg_midscale = 1'b1;
      rst_n = 1'b0;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      chk("R5 code midscale", 32'(dac_code), 32'h8000);

      for (int v = 0; v < NVEC; v++) begin
         send(VEC[v][47:24], int'(VEC[v][23:19]), VEC[v][18]);
         chk($sformatf("vector %0d code (R1/R2/R4/R6/R7/R9)", v), 32'(dac_code), 32'(VEC[v][17:2]));
         chk($sformatf("vector %0d mode (R3)", v), 32'(pd_mode), 32'(VEC[v][1:0]));
         chk($sformatf("vector %0d selects (R3)", v),
             32'({amp_drive, term_open, term_100k, term_1k}), 32'(exp_sel(VEC[v][1:0])));
      end

      // R10: extra edges after a full word
      send(24'h002468, 28, 1'b0);
      chk("R10 extra edges ignored", 32'(dac_code), 32'h2468);

      // R8: wake timing
      wait_cyc(400);
      send(24'h010000, 24, 1'b0);
      chk("R8 not ready in power-down", 32'(out_ready), 32'd0);
      measured = 0;
      send(24'h002222, 24, 1'b0);
      chk("R8 code after exit", 32'(dac_code), 32'h2222);
      wait_cyc(EXIT_EXP + 50);
      chk("R8 wake cycles", 32'(measured), 32'(EXIT_EXP));
      chk("R8 ready after wake", 32'(out_ready), 32'd1);

      // R6: reset word follows the strap
      cfg_midscale = 1'b0;
      send(24'hFFFFFF, 24, 1'b0);
      chk("R6 reset to zero-scale", 32'(dac_code), 32'h0000);

      // R7: committed reset from power-down, aborted after 9 bits
      send(24'h030000, 24, 1'b0);
      send(24'hFF8000, 9, 1'b0);
      chk("R7 early-rise reset mode", 32'(pd_mode), 32'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule